// File: doc/BRIEF.md
# DRAM Bank Command Scheduler

This block decides, cycle by cycle, which single command a multi-bank DRAM controller sends to the memory: open a row (ACTIVATE), close a row (PRECHARGE), a column READ, a column WRITE, or nothing (NOP). Each bank owns one request slot that holds a row, a starting column, a byte count and a read/write flag. A request producer fills a slot through a load port and watches the per-bank busy flags to know which slots are free. From then on the scheduler opens the right row, moves the data in bursts and frees the slot when the last burst has been issued.

Row and column timing is enforced by saturating down-counters: some belong to each bank and some are shared by all banks. The timing values are inputs, so one netlist serves several speed grades. The activate-to-write delay and the read-to-write bus turnaround are not separate inputs: the block derives them from the read latency, the write latency and the burst length. Every issued READ or WRITE also produces a push into a downstream data-return queue. That queue can stall column commands through a full flag. A direction flag and a one-cycle pulse tell the queue which latency (read or write) now applies.

Top module: `dram_cmd_sched`

## Requirements
- R1: While reset is high and in the first cycle after it, the outputs show NOP (cmd_o = 0), no push, read direction (dir_write_o = 0) and no busy slot. Reset leaves every bank idle, every counter at zero and the scan start at bank 0.
- R2: At most one command is issued per cycle, encoded on cmd_o as NOP=0, ACTIVATE=1, PRECHARGE=2, READ=3, WRITE=4. A request loaded at a clock edge into a free slot can first appear on cmd_o one edge later.
- R3: An idle bank with a pending request is activated only when the shared activate-to-activate counter (t_rrd) and its own precharge (t_rp) and row-cycle (t_rc) counters are all zero. Consecutive ACTIVATEs are therefore at least t_rrd cycles apart, and a READ follows its ACTIVATE by at least t_rcd cycles.
- R4: A WRITE may follow an ACTIVATE of its bank after max(t_rcd − (t_wl + 1), 0) cycles.
- R5: Two column commands (READ or WRITE) are at least t_ccd cycles apart.
- R6: A WRITE may follow a READ no sooner than t_cl + t_bl/2 + 2 − t_wl cycles later (floored at 0). A READ after a WRITE waits only for t_ccd.
- R7: A bank whose open row differs from its request's row is precharged once t_ras cycles have passed since its ACTIVATE. cmd_row_o then shows the row being closed, and the next ACTIVATE of that bank waits t_rp cycles.
- R8: While rq_full_i is high, no READ or WRITE is issued and no push happens. ACTIVATE and PRECHARGE are not affected.
- R9: Banks are scanned from a start index upward, modulo the bank count, and the first eligible bank wins. The start index moves to the bank after the winner following an ACTIVATE or PRECHARGE, but stays put after a READ or WRITE.
- R10: Each READ or WRITE moves t_bl × BUS_BYTES bytes. cmd_col_o shows the start column plus the bytes already moved. The slot is freed, with push_last_o high, on the burst that brings the moved count to at least the request length.
- R11: dir_write_o is 1 after a WRITE and 0 after a READ. dir_flip_o pulses for one cycle, together with the command, exactly when the direction changes.
- R12: A load aimed at a busy slot is ignored. slot_busy_o shows, per bank, whether its slot holds a request.
- R13: A row-hit READ or WRITE of a bank takes precedence over any ACTIVATE or PRECHARGE for that same bank. Row state is only changed for a bank whose open row does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| t_ccd_i | input | T_W | Column-to-column spacing |
| t_rrd_i | input | T_W | Activate-to-activate spacing (any banks) |
| t_rcd_i | input | T_W | Activate-to-read delay |
| t_ras_i | input | T_W | Minimum row-open time before precharge |
| t_rp_i | input | T_W | Precharge-to-activate delay |
| t_rc_i | input | T_W | Activate-to-activate delay, same bank |
| t_cl_i | input | T_W | Read latency |
| t_wl_i | input | T_W | Write latency |
| t_bl_i | input | T_W | Burst length |
| req_valid_i | input | 1 | Load a request into a slot |
| req_bank_i | input | BK_W | Target bank of the load |
| req_row_i | input | ROW_W | Requested row |
| req_col_i | input | COL_W | Starting column |
| req_len_i | input | LEN_W | Request size in bytes |
| req_write_i | input | 1 | 1 = write request, 0 = read |
| rq_full_i | input | 1 | Data-return queue full |
| slot_busy_o | output | NUM_BANKS | Per-bank slot occupied |
| cmd_o | output | 3 | Issued command code |
| cmd_bank_o | output | BK_W | Bank of the issued command |
| cmd_row_o | output | ROW_W | Row of the issued command |
| cmd_col_o | output | COL_W | Column of a READ/WRITE |
| push_o | output | 1 | Push into data-return queue |
| push_write_o | output | 1 | Pushed burst is a write |
| push_last_o | output | 1 | Pushed burst completes its request |
| dir_write_o | output | 1 | Current bus direction (1 = write) |
| dir_flip_o | output | 1 | Direction changed with this command |

## Verification
The spacing properties take for granted that the timing inputs stay fixed while requests are in flight. The return-queue property assumes that rq_full_i is driven from a register, so its value in the decision cycle is the one sampled. The stimulus programs all timing values once, during reset, and changes rq_full_i only between clock edges. It loads a bank only to build a scenario whose command times can be derived by hand: row hits, row misses, write/read turnarounds, two banks contending for the scan, and a load sent to a busy slot while reads are held back.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } cmd_e;
endpackage

// File: rtl/dcs_dcnt.sv
// Saturating timing down-counter: a load of V gives V-1 after the edge,
// so the guarded event may next occur V cycles after the loading cycle.
module dcs_dcnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (ld) begin
      cnt <= (ld_val != '0) ? ld_val - W'(1) : '0;
    end else if (cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/dcs_pick.sv
// Rotating first-eligible selector starting at index prio.
module dcs_pick #(
  parameter int N    = 4,
  parameter int BK_W = 2
) (
  input  logic [N-1:0]    elig,
  input  logic [BK_W-1:0] prio,
  output logic            hit,
  output logic [BK_W-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(prio) + k;
      if (j >= N) j = j - N;
      if (!hit && elig[j]) begin
        hit = 1'b1;
        idx = BK_W'(j);
      end
    end
  end
endmodule

// File: rtl/dcs_bank.sv
// One bank: request slot, open-row state and per-bank timing counters.
module dcs_bank #(
  parameter int ROW_W = 10,
  parameter int COL_W = 8,
  parameter int LEN_W = 8,
  parameter int T_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ROW_W-1:0] load_row,
  input  logic [COL_W-1:0] load_col,
  input  logic [LEN_W-1:0] load_len,
  input  logic             load_wr,
  input  logic             gnt_act,
  input  logic             gnt_pre,
  input  logic             gnt_xfer,
  input  logic [LEN_W:0]   xfer_bytes,
  input  logic [T_W-1:0]   t_rcd,
  input  logic [T_W-1:0]   t_rcdwr,
  input  logic [T_W-1:0]   t_ras,
  input  logic [T_W-1:0]   t_rc,
  input  logic [T_W-1:0]   t_rp,
  output logic             busy,
  output logic             rd_ok,
  output logic             wr_ok,
  output logic             act_ok,
  output logic             pre_ok,
  output logic             is_wr,
  output logic             last_xfer,
  output logic [ROW_W-1:0] row_sel,
  output logic [COL_W-1:0] col_cur
);
  logic             slot_v;
  logic [ROW_W-1:0] s_row;
  logic [COL_W-1:0] s_col;
  logic [LEN_W-1:0] s_len;
  logic             s_wr;
  logic [LEN_W:0]   moved;
  logic             opened;
  logic [ROW_W-1:0] open_row;
  logic             rcd_z, rcdwr_z, ras_z, rc_z, rp_z;
  logic [LEN_W+1:0] moved_nxt;
  logic             hit_row;

  dcs_dcnt #(.W(T_W)) u_rcd   (.clk(clk), .rst(rst), .ld(gnt_act), .ld_val(t_rcd),   .zero(rcd_z));
  dcs_dcnt #(.W(T_W)) u_rcdwr (.clk(clk), .rst(rst), .ld(gnt_act), .ld_val(t_rcdwr), .zero(rcdwr_z));
  dcs_dcnt #(.W(T_W)) u_ras   (.clk(clk), .rst(rst), .ld(gnt_act), .ld_val(t_ras),   .zero(ras_z));
  dcs_dcnt #(.W(T_W)) u_rc    (.clk(clk), .rst(rst), .ld(gnt_act), .ld_val(t_rc),    .zero(rc_z));
  dcs_dcnt #(.W(T_W)) u_rp    (.clk(clk), .rst(rst), .ld(gnt_pre), .ld_val(t_rp),    .zero(rp_z));

  assign moved_nxt = {1'b0, moved} + {1'b0, xfer_bytes};
  assign last_xfer = (moved_nxt >= (LEN_W+2)'(s_len));
  assign hit_row   = opened && (open_row == s_row);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_v   <= 1'b0;
      s_row    <= '0;
      s_col    <= '0;
      s_len    <= '0;
      s_wr     <= 1'b0;
      moved    <= '0;
      opened   <= 1'b0;
      open_row <= '0;
    end else begin
      if (load && !slot_v) begin
        slot_v <= 1'b1;
        s_row  <= load_row;
        s_col  <= load_col;
        s_len  <= load_len;
        s_wr   <= load_wr;
        moved  <= '0;
      end else if (gnt_xfer) begin
        if (last_xfer) begin
          slot_v <= 1'b0;
          moved  <= '0;
        end else begin
          moved <= moved_nxt[LEN_W:0];
        end
      end
      if (gnt_act) begin
        opened   <= 1'b1;
        open_row <= s_row;
      end else if (gnt_pre) begin
        opened <= 1'b0;
      end
    end
  end

  assign busy    = slot_v;
  assign is_wr   = s_wr;
  assign rd_ok   = slot_v && hit_row && !s_wr && rcd_z;
  assign wr_ok   = slot_v && hit_row &&  s_wr && rcdwr_z;
  assign act_ok  = slot_v && !opened && rp_z && rc_z;
  assign pre_ok  = slot_v && opened && (open_row != s_row) && ras_z;
  assign row_sel = gnt_pre ? open_row : s_row;
  assign col_cur = s_col + COL_W'(moved);
endmodule

// File: rtl/dram_cmd_sched.sv
module dram_cmd_sched #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 10,
  parameter int COL_W     = 8,
  parameter int LEN_W     = 8,
  parameter int T_W       = 6,
  parameter int BUS_BYTES = 4,
  localparam int BK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [T_W-1:0]       t_ccd_i,
  input  logic [T_W-1:0]       t_rrd_i,
  input  logic [T_W-1:0]       t_rcd_i,
  input  logic [T_W-1:0]       t_ras_i,
  input  logic [T_W-1:0]       t_rp_i,
  input  logic [T_W-1:0]       t_rc_i,
  input  logic [T_W-1:0]       t_cl_i,
  input  logic [T_W-1:0]       t_wl_i,
  input  logic [T_W-1:0]       t_bl_i,
  input  logic                 req_valid_i,
  input  logic [BK_W-1:0]      req_bank_i,
  input  logic [ROW_W-1:0]     req_row_i,
  input  logic [COL_W-1:0]     req_col_i,
  input  logic [LEN_W-1:0]     req_len_i,
  input  logic                 req_write_i,
  input  logic                 rq_full_i,
  output logic [NUM_BANKS-1:0] slot_busy_o,
  output logic [2:0]           cmd_o,
  output logic [BK_W-1:0]      cmd_bank_o,
  output logic [ROW_W-1:0]     cmd_row_o,
  output logic [COL_W-1:0]     cmd_col_o,
  output logic                 push_o,
  output logic                 push_write_o,
  output logic                 push_last_o,
  output logic                 dir_write_o,
  output logic                 dir_flip_o
);
  import dcs_pkg::*;

  localparam int SW = T_W + 2;
  localparam int XW = T_W + 16;

  // derived timing
  logic [SW-1:0]    wl_p1, rtw_sum, rtw_raw;
  logic [T_W-1:0]   t_rcdwr, t_rtw;
  logic [XW-1:0]    xfer_full;
  logic [LEN_W:0]   xfer_bytes;

  assign wl_p1     = SW'(t_wl_i) + SW'(1);
  assign t_rcdwr   = (SW'(t_rcd_i) > wl_p1) ? T_W'(SW'(t_rcd_i) - wl_p1) : '0;
  assign rtw_sum   = SW'(t_cl_i) + SW'(t_bl_i >> 1) + SW'(2);
  assign rtw_raw   = (rtw_sum > SW'(t_wl_i)) ? rtw_sum - SW'(t_wl_i) : '0;
  assign t_rtw     = (rtw_raw > SW'({T_W{1'b1}})) ? {T_W{1'b1}} : T_W'(rtw_raw);
  assign xfer_full = XW'(t_bl_i) * XW'(BUS_BYTES);
  assign xfer_bytes = (LEN_W+1)'(xfer_full);

  // per-bank status
  logic [NUM_BANKS-1:0] b_busy, b_rd, b_wr, b_act, b_pre, b_iswr, b_last;
  logic [NUM_BANKS-1:0] g_act, g_pre, g_xfer, b_load;
  logic [ROW_W-1:0]     b_row [NUM_BANKS];
  logic [COL_W-1:0]     b_col [NUM_BANKS];
  logic [NUM_BANKS-1:0] e_rd, e_wr, e_act, e_pre, elig;

  // shared counters
  logic ccd_z, rrd_z, rtw_z;

  // scan and decision
  logic [BK_W-1:0] prio_q;
  logic            hit;
  logic [BK_W-1:0] idx;
  logic            sel_rd, sel_wr, sel_act, sel_pre;
  logic            dir_w_q;

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign b_load[b] = req_valid_i && (req_bank_i == BK_W'(b));
      assign g_act[b]  = sel_act && (idx == BK_W'(b));
      assign g_pre[b]  = sel_pre && (idx == BK_W'(b));
      assign g_xfer[b] = (sel_rd || sel_wr) && (idx == BK_W'(b));

      dcs_bank #(.ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W), .T_W(T_W)) u_bank (
        .clk(clk), .rst(rst),
        .load(b_load[b]), .load_row(req_row_i), .load_col(req_col_i),
        .load_len(req_len_i), .load_wr(req_write_i),
        .gnt_act(g_act[b]), .gnt_pre(g_pre[b]), .gnt_xfer(g_xfer[b]),
        .xfer_bytes(xfer_bytes),
        .t_rcd(t_rcd_i), .t_rcdwr(t_rcdwr), .t_ras(t_ras_i), .t_rc(t_rc_i), .t_rp(t_rp_i),
        .busy(b_busy[b]), .rd_ok(b_rd[b]), .wr_ok(b_wr[b]), .act_ok(b_act[b]),
        .pre_ok(b_pre[b]), .is_wr(b_iswr[b]), .last_xfer(b_last[b]),
        .row_sel(b_row[b]), .col_cur(b_col[b])
      );

      assign e_rd[b]  = b_rd[b] && ccd_z && !rq_full_i;
      assign e_wr[b]  = b_wr[b] && ccd_z && rtw_z && !rq_full_i;
      assign e_act[b] = b_act[b] && rrd_z;
      assign e_pre[b] = b_pre[b];
      assign elig[b]  = e_rd[b] || e_wr[b] || e_act[b] || e_pre[b];
    end
  endgenerate

  dcs_pick #(.N(NUM_BANKS), .BK_W(BK_W)) u_pick (
    .elig(elig), .prio(prio_q), .hit(hit), .idx(idx)
  );

  assign sel_rd  = hit && e_rd[idx];
  assign sel_wr  = hit && e_wr[idx];
  assign sel_act = hit && e_act[idx];
  assign sel_pre = hit && e_pre[idx];

  dcs_dcnt #(.W(T_W)) u_ccd (.clk(clk), .rst(rst), .ld(sel_rd || sel_wr), .ld_val(t_ccd_i), .zero(ccd_z));
  dcs_dcnt #(.W(T_W)) u_rrd (.clk(clk), .rst(rst), .ld(sel_act),          .ld_val(t_rrd_i), .zero(rrd_z));
  dcs_dcnt #(.W(T_W)) u_rtw (.clk(clk), .rst(rst), .ld(sel_rd),           .ld_val(t_rtw),   .zero(rtw_z));

  cmd_e cmd_d;
  always_comb begin
    cmd_d = CMD_NOP;
    if (sel_rd)       cmd_d = CMD_RD;
    else if (sel_wr)  cmd_d = CMD_WR;
    else if (sel_act) cmd_d = CMD_ACT;
    else if (sel_pre) cmd_d = CMD_PRE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q       <= '0;
      dir_w_q      <= 1'b0;
      dir_flip_o   <= 1'b0;
      cmd_o        <= CMD_NOP;
      cmd_bank_o   <= '0;
      cmd_row_o    <= '0;
      cmd_col_o    <= '0;
      push_o       <= 1'b0;
      push_write_o <= 1'b0;
      push_last_o  <= 1'b0;
    end else begin
      if (sel_act || sel_pre)
        prio_q <= (idx == BK_W'(NUM_BANKS - 1)) ? '0 : idx + BK_W'(1);
      dir_flip_o <= (sel_rd && dir_w_q) || (sel_wr && !dir_w_q);
      if (sel_rd)      dir_w_q <= 1'b0;
      else if (sel_wr) dir_w_q <= 1'b1;
      cmd_o        <= cmd_d;
      cmd_bank_o   <= hit ? idx : '0;
      cmd_row_o    <= hit ? b_row[idx] : '0;
      cmd_col_o    <= (sel_rd || sel_wr) ? b_col[idx] : '0;
      push_o       <= sel_rd || sel_wr;
      push_write_o <= sel_wr;
      push_last_o  <= (sel_rd || sel_wr) && b_last[idx];
    end
  end

  assign dir_write_o = dir_w_q;
  assign slot_busy_o = b_busy;

  logic unused_ok;
  assign unused_ok = ^b_iswr;
endmodule

// File: rtl/dcs_sched_chk.sv
module dcs_sched_chk #(
  parameter int T_W = 6
) (
  input logic           clk,
  input logic           rst,
  input logic [T_W-1:0] t_ccd_i,
  input logic [T_W-1:0] t_rrd_i,
  input logic           rq_full_i,
  input logic [2:0]     cmd_o,
  input logic           push_o,
  input logic           push_last_o,
  input logic           dir_write_o,
  input logic           dir_flip_o
);
  logic col_cmd;
  assign col_cmd = (cmd_o == 3'd3) || (cmd_o == 3'd4);

  p_cmd_code_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_o <= 3'd4);
  p_rrd_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'd1 && t_rrd_i > 1) |=> cmd_o != 3'd1);
  p_ccd_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (col_cmd && t_ccd_i > 1) |=> !col_cmd);
  p_full_stall_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rq_full_i) |-> !push_o);
  p_push_cmd_r10: assert property (@(posedge clk) disable iff (rst)
    push_o |-> col_cmd);
  p_last_push_r10: assert property (@(posedge clk) disable iff (rst)
    push_last_o |-> push_o);
  p_rd_dir_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_o == 3'd3 |-> !dir_write_o);
  p_wr_dir_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_o == 3'd4 |-> dir_write_o);
  p_flip_r11: assert property (@(posedge clk) disable iff (rst)
    dir_flip_o |-> dir_write_o != $past(dir_write_o));
endmodule

bind dram_cmd_sched dcs_sched_chk #(.T_W(T_W)) chk_i (
  .clk(clk), .rst(rst), .t_ccd_i(t_ccd_i), .t_rrd_i(t_rrd_i),
  .rq_full_i(rq_full_i), .cmd_o(cmd_o), .push_o(push_o),
  .push_last_o(push_last_o), .dir_write_o(dir_write_o), .dir_flip_o(dir_flip_o)
);

// File: tb/dram_cmd_sched_tb_top.sv
module dram_cmd_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int NOP = 0, ACT = 1, PRE = 2, RD = 3, WR = 4;
  // timing set used throughout
  localparam int TCCD = 2, TRRD = 3, TRCD = 4, TRAS = 6, TRP = 3, TRC = 11;
  localparam int TCL = 5, TWL = 2, TBL = 4, BUSB = 4;
  localparam int RCDWR = (TRCD > TWL + 1) ? TRCD - TWL - 1 : 0;
  localparam int RTW   = TCL + TBL / 2 + 2 - TWL;
  localparam int XFER  = TBL * BUSB;

  logic clk = 1'b0, rst = 1'b1;
  logic [5:0] t_ccd, t_rrd, t_rcd, t_ras, t_rp, t_rc, t_cl, t_wl, t_bl;
  logic req_valid = 1'b0, req_write = 1'b0, rq_full = 1'b0;
  logic [1:0] req_bank = '0;
  logic [9:0] req_row = '0;
  logic [7:0] req_col = '0, req_len = '0;
  logic [NB-1:0] slot_busy;
  logic [2:0] cmd;
  logic [1:0] cmd_bank;
  logic [9:0] cmd_row;
  logic [7:0] cmd_col;
  logic push, push_wr, push_last, dir_w, dir_flip;

  int errors = 0, checks = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_cmd_sched #(.NUM_BANKS(NB), .BUS_BYTES(BUSB)) dut_i (
    .clk(clk), .rst(rst),
    .t_ccd_i(t_ccd), .t_rrd_i(t_rrd), .t_rcd_i(t_rcd), .t_ras_i(t_ras),
    .t_rp_i(t_rp), .t_rc_i(t_rc), .t_cl_i(t_cl), .t_wl_i(t_wl), .t_bl_i(t_bl),
    .req_valid_i(req_valid), .req_bank_i(req_bank), .req_row_i(req_row),
    .req_col_i(req_col), .req_len_i(req_len), .req_write_i(req_write),
    .rq_full_i(rq_full), .slot_busy_o(slot_busy), .cmd_o(cmd),
    .cmd_bank_o(cmd_bank), .cmd_row_o(cmd_row), .cmd_col_o(cmd_col),
    .push_o(push), .push_write_o(push_wr), .push_last_o(push_last),
    .dir_write_o(dir_w), .dir_flip_o(dir_flip)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // drive a load; caller is at a negedge, load lands at the next posedge
  task automatic load(int b, int row, int col, int len, int wr, output int t);
    t = cyc;
    req_valid = 1'b1; req_bank = 2'(b); req_row = 10'(row);
    req_col = 8'(col); req_len = 8'(len); req_write = wr[0];
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic next_cmd(output int t);
    int n;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (cmd == 3'(NOP) && n < 200);
    if (n >= 200) chk("watchdog: no command", 0, 1);
    t = cyc;
  endtask

  task automatic expect_cmd(string tag, int c, int b, int row, int base, int dt, output int t);
    next_cmd(t);
    chk({tag, " cmd"}, int'(cmd), c);
    chk({tag, " bank"}, int'(cmd_bank), b);
    chk({tag, " row"}, int'(cmd_row), row);
    chk({tag, " delay"}, t - base, dt);
  endtask

  task automatic quiet(string tag, int n);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cmd != 3'(NOP)) seen++;
    end
    chk(tag, seen, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int t0, t1, t2, t3;
    t_ccd = 6'(TCCD); t_rrd = 6'(TRRD); t_rcd = 6'(TRCD); t_ras = 6'(TRAS);
    t_rp = 6'(TRP); t_rc = 6'(TRC); t_cl = 6'(TCL); t_wl = 6'(TWL); t_bl = 6'(TBL);
    repeat (4) @(negedge clk);
    chk("R1 reset cmd", int'(cmd), NOP);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cmd after reset", int'(cmd), NOP);
    chk("R1 dir after reset", int'(dir_w), 0);
    chk("R1 slots after reset", int'(slot_busy), 0);
    chk("R1 push after reset", int'(push), 0);

    // A: read of two bursts on bank 1
    load(1, 5, 8, 2 * XFER, 0, t0);
    expect_cmd("R2 first ACT", ACT, 1, 5, t0, 2, t1);
    expect_cmd("R3 RD after tRCD", RD, 1, 5, t1, TRCD, t2);
    chk("R10 col first burst", int'(cmd_col), 8);
    chk("R10 not last", int'(push_last), 0);
    chk("R10 push read", int'(push) * 2 + int'(push_wr), 2);
    expect_cmd("R5 second RD after tCCD", RD, 1, 5, t2, TCCD, t3);
    chk("R10 col second burst", int'(cmd_col), 8 + XFER);
    chk("R10 last burst", int'(push_last), 1);
    chk("R10 slot freed", int'(slot_busy), 0);
    quiet("R2 no stray command", 20);

    // B: row-hit write flips direction, then read flips back
    load(1, 5, 0, XFER, 1, t0);
    expect_cmd("R13 row-hit WR", WR, 1, 5, t0, 2, t1);
    chk("R11 dir to write", int'(dir_w), 1);
    chk("R11 flip on WR", int'(dir_flip), 1);
    chk("R10 push write", int'(push_wr), 1);
    load(1, 5, 0, XFER, 0, t0);
    @(negedge clk);
    chk("R11 flip is one pulse", int'(dir_flip), 0);
    next_cmd(t2);
    chk("R6 RD after WR cmd", int'(cmd), RD);
    chk("R6 RD after WR waits only tCCD", t2 - t1, TCCD);
    chk("R11 dir to read", int'(dir_w), 0);
    chk("R11 flip on RD", int'(dir_flip), 1);
    // C: write right after that read
    load(1, 5, 0, XFER, 1, t0);
    expect_cmd("R6 read-to-write turnaround", WR, 1, 5, t2, RTW, t1);
    quiet("R6 idle", 20);

    // D: row miss on bank 1
    load(1, 9, 0, XFER, 0, t0);
    expect_cmd("R7 PRE closes old row", PRE, 1, 5, t0, 2, t1);
    expect_cmd("R7 ACT after tRP", ACT, 1, 9, t1, TRP, t2);
    expect_cmd("R3 RD after new ACT", RD, 1, 9, t2, TRCD, t3);
    quiet("R7 idle", 20);

    // E: write soon after ACT, then a row miss limited by tRC
    load(2, 3, 0, XFER, 1, t0);
    expect_cmd("R9 ACT bank 2", ACT, 2, 3, t0, 2, t1);
    expect_cmd("R4 WR after derived delay", WR, 2, 3, t1, (RCDWR > 1) ? RCDWR : 1, t2);
    load(2, 8, 0, XFER, 0, t0);
    expect_cmd("R7 PRE after tRAS", PRE, 2, 3, t1, TRAS, t2);
    expect_cmd("R3 ACT held by tRC", ACT, 2, 8, t1, TRC, t2);
    expect_cmd("R3 RD bank 2", RD, 2, 8, t2, TRCD, t3);
    quiet("R3 idle", 20);

    // F: two activates spaced by tRRD
    load(0, 1, 0, XFER, 0, t0);
    load(3, 1, 0, XFER, 0, t1);
    expect_cmd("R3 ACT bank 0", ACT, 0, 1, t0, 2, t1);
    expect_cmd("R3 ACT spacing tRRD", ACT, 3, 1, t1, TRRD, t2);
    expect_cmd("R3 RD bank 0", RD, 0, 1, t1, TRCD, t3);
    expect_cmd("R3 RD bank 3", RD, 3, 1, t2, TRCD, t3);
    quiet("R3 idle F", 20);

    // I: queue full stalls reads; busy-slot load ignored; scan from bank 0
    rq_full = 1'b1;
    load(3, 1, 0, XFER, 0, t0);
    load(0, 1, 0, XFER, 0, t0);
    load(0, 7, 0, XFER, 1, t0);
    @(negedge clk);
    chk("R12 busy flags", int'(slot_busy), 9);
    quiet("R8 reads held while full", 6);
    t0 = cyc;
    rq_full = 1'b0;
    expect_cmd("R9 scan picks bank 0", RD, 0, 1, t0, 1, t1);
    expect_cmd("R5 next RD bank 3", RD, 3, 1, t1, TCCD, t2);
    chk("R12 slots empty", int'(slot_busy), 0);
    quiet("R12 ignored load left no command", 20);

    // J: two precharges then two activates, scan start rotating
    load(3, 4, 0, XFER, 0, t0);
    load(0, 4, 0, XFER, 0, t1);
    expect_cmd("R9 PRE bank 3", PRE, 3, 1, t0, 2, t1);
    expect_cmd("R9 PRE bank 0", PRE, 0, 1, t1, 1, t2);
    expect_cmd("R9 ACT bank 3", ACT, 3, 4, t1, TRP, t2);
    expect_cmd("R9 ACT bank 0", ACT, 0, 4, t2, TRRD, t3);
    expect_cmd("R9 RD bank 3", RD, 3, 4, t2, TRCD, t2);
    expect_cmd("R9 RD bank 0", RD, 0, 4, t3, TRCD, t3);
    quiet("R9 idle J", 20);

    // K: scan start now bank 1, so bank 3 wins over bank 0
    rq_full = 1'b1;
    load(0, 4, 0, XFER, 0, t0);
    load(3, 4, 0, XFER, 0, t0);
    quiet("R8 held K", 3);
    t0 = cyc;
    rq_full = 1'b0;
    expect_cmd("R9 wrap picks bank 3", RD, 3, 4, t0, 1, t1);
    expect_cmd("R9 then bank 0", RD, 0, 4, t1, TCCD, t2);
    quiet("R9 idle K", 10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule